// File: doc/BRIEF.md
# Telemetry Frame Word Reformatter

This block sits in a byte-wide telemetry stream whose frames have a fixed shape. Each frame opens with a four-byte synchronisation field, then one line-number byte, then a fixed count of 8-bit intensity samples. The block tracks where each incoming byte falls in the frame and tags it with its class. Intensity samples are rewritten on the way through. The bit order of each sample is turned end for end, then a programmable mask inverts selected bits of the reversed value. Sync and line-number bytes leave the block untouched.

The block does not search for the sync pattern. An upstream framer pulses a start-of-frame strobe, and that strobe realigns the position tracker. Bytes enter and leave through valid/ready handshakes. One output register holds the result, so each accepted byte appears one cycle later. Back-pressure on the output stalls the input, and no byte is lost or repeated.

Top module: `tlm_frame_reformatter`

## Requirements
- R1: After reset, out_valid is 0, in_ready is 1, the XOR mask holds 8'h2A, and the next accepted byte is treated as the first sync byte.
- R2: Once aligned, accepted bytes are classed in a repeating cycle: SYNC_BYTES sync bytes, then one line byte, then DATA_BYTES data bytes. The next frame then starts with no strobe needed.
- R3: Every output byte carries out_class, coded as 2'b01 for sync, 2'b10 for line and 2'b11 for data. The code 2'b00 never appears with out_valid high.
- R4: A data byte leaves as its bit-reversed value XOR the mask. Input bit 7 moves to output bit 0, input bit 0 moves to output bit 7, and so on. Mask bit k inverts output bit k.
- R5: Sync and line-number bytes leave with their data equal to the accepted input byte.
- R6: A cycle with mask_wr high loads mask_wr_data into the mask. Bytes accepted in later cycles use the new mask. A byte accepted in the same cycle as the write still uses the old mask.
- R7: When sof is high in a cycle that accepts a byte, that byte is sync byte 0 of a new frame. When sof is high and no byte is accepted, the next accepted byte is sync byte 0. Either rule applies from any frame position.
- R8: While out_valid is 1 and out_ready is 0, the outputs hold their values and in_ready is 0. Each accepted input byte appears on the output exactly once, in order.
- R9: A byte is accepted when in_valid and in_ready are both 1, and in_ready equals (not out_valid) or out_ready. An accepted byte is presented on the output after the next clock edge. With out_ready held high, one byte per cycle passes through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sof | input | 1 | Start-of-frame strobe that realigns the position tracker |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Block can take an input byte |
| in_data | input | BYTE_W | Input byte |
| mask_wr | input | 1 | Load strobe for the XOR mask |
| mask_wr_data | input | BYTE_W | New mask value |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Sink can take the output byte |
| out_data | output | BYTE_W | Output byte |
| out_class | output | 2 | Byte class tag (01 sync, 10 line, 11 data) |

## Verification
The hardest cases to reach combine several events in one cycle. One is a start-of-frame strobe that lands on a stalled cycle in the middle of the data run. Another is a mask write in the same cycle as an accepted data byte. A third is the wrap from the last data byte into the next sync field while the output is back-pressured. The stimulus shrinks the data run so that many frames wrap within a short run. It then mixes random valid, ready, strobe and mask-write patterns. A behavioural model tracks the frame position as a plain integer and predicts every output and in_ready value on every cycle.

// File: rtl/tfr_pkg.sv
package tfr_pkg;
  typedef enum logic [1:0] {
    CLS_NONE = 2'b00,
    CLS_SYNC = 2'b01,
    CLS_LINE = 2'b10,
    CLS_DATA = 2'b11
  } byte_class_e;

  typedef enum logic [1:0] {
    PH_SYNC = 2'd0,
    PH_LINE = 2'd1,
    PH_DATA = 2'd2
  } frame_phase_e;
endpackage

// File: rtl/tfr_position.sv
module tfr_position
  import tfr_pkg::*;
#(
  parameter int SYNC_BYTES = 4,
  parameter int DATA_BYTES = 242
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        sof_i,
  input  logic        step_i,
  output byte_class_e cls_o
);
  localparam int MAX_CNT = (SYNC_BYTES > DATA_BYTES) ? SYNC_BYTES : DATA_BYTES;
  localparam int CNT_W   = $clog2(MAX_CNT + 1);
  localparam logic [CNT_W-1:0] SYNC_LAST = CNT_W'(SYNC_BYTES - 1);
  localparam logic [CNT_W-1:0] DATA_LOAD = CNT_W'(DATA_BYTES);

  frame_phase_e     ph_q, eff_ph;
  logic [CNT_W-1:0] cnt_q, eff_cnt;

  // The strobe overrides the stored position in the same cycle.
  always_comb begin
    eff_ph  = sof_i ? PH_SYNC : ph_q;
    eff_cnt = sof_i ? '0 : cnt_q;
    case (eff_ph)
      PH_SYNC: cls_o = CLS_SYNC;
      PH_LINE: cls_o = CLS_LINE;
      PH_DATA: cls_o = CLS_DATA;
      default: cls_o = CLS_NONE;
    endcase
  end

  // In the sync phase cnt is the sync index. In the data phase it is the
  // count of data bytes still to come, the current one included.
  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q  <= PH_SYNC;
      cnt_q <= '0;
    end else if (step_i) begin
      case (eff_ph)
        PH_SYNC: begin
          if (eff_cnt == SYNC_LAST) begin
            ph_q  <= PH_LINE;
            cnt_q <= '0;
          end else begin
            ph_q  <= PH_SYNC;
            cnt_q <= eff_cnt + 1'b1;
          end
        end
        PH_LINE: begin
          ph_q  <= PH_DATA;
          cnt_q <= DATA_LOAD;
        end
        PH_DATA: begin
          if (eff_cnt == CNT_W'(1)) begin
            ph_q  <= PH_SYNC;
            cnt_q <= '0;
          end else begin
            ph_q  <= PH_DATA;
            cnt_q <= eff_cnt - 1'b1;
          end
        end
        default: begin
          ph_q  <= PH_SYNC;
          cnt_q <= '0;
        end
      endcase
    end else if (sof_i) begin
      ph_q  <= PH_SYNC;
      cnt_q <= '0;
    end
  end

  AST_DATA_REMAIN_RANGE: assert property (@(posedge clk) disable iff (rst)
    ph_q == PH_DATA |-> (cnt_q != '0 && cnt_q <= DATA_LOAD)); // R2
  AST_SYNC_INDEX_RANGE: assert property (@(posedge clk) disable iff (rst)
    ph_q == PH_SYNC |-> cnt_q <= SYNC_LAST); // R2
  AST_SOF_REALIGNS: assert property (@(posedge clk) disable iff (rst)
    (sof_i && !step_i) |=> (ph_q == PH_SYNC && cnt_q == '0)); // R7
endmodule

// File: rtl/tfr_byte_xform.sv
module tfr_byte_xform
  import tfr_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic [BYTE_W-1:0] byte_i,
  input  logic [BYTE_W-1:0] mask_i,
  input  byte_class_e       cls_i,
  output logic [BYTE_W-1:0] byte_o
);
  logic [BYTE_W-1:0] rev;

  for (genvar i = 0; i < BYTE_W; i++) begin : g_rev
    assign rev[i] = byte_i[BYTE_W-1-i];
  end

  always_comb begin
    byte_o = (cls_i == CLS_DATA) ? (rev ^ mask_i) : byte_i;
  end
endmodule

// File: rtl/tfr_out_stage.sv
module tfr_out_stage
  import tfr_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [BYTE_W-1:0] data_i,
  input  byte_class_e       cls_i,
  input  logic              out_ready_i,
  output logic              ready_o,
  output logic              out_valid_o,
  output logic [BYTE_W-1:0] out_data_o,
  output byte_class_e       out_class_o
);
  assign ready_o = !out_valid_o || out_ready_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid_o <= 1'b0;
      out_data_o  <= '0;
      out_class_o <= CLS_NONE;
    end else if (load_i) begin
      out_valid_o <= 1'b1;
      out_data_o  <= data_i;
      out_class_o <= cls_i;
    end else if (out_ready_i) begin
      out_valid_o <= 1'b0;
    end
  end

  AST_HOLD_UNDER_STALL: assert property (@(posedge clk) disable iff (rst)
    (out_valid_o && !out_ready_i) |=>
      (out_valid_o && $stable(out_data_o) && $stable(out_class_o))); // R8
  AST_NO_LOAD_WHEN_BLOCKED: assert property (@(posedge clk) disable iff (rst)
    (out_valid_o && !out_ready_i) |-> !load_i); // R8
endmodule

// File: rtl/tlm_frame_reformatter.sv
module tlm_frame_reformatter
  import tfr_pkg::*;
#(
  parameter int                BYTE_W     = 8,
  parameter int                SYNC_BYTES = 4,
  parameter int                DATA_BYTES = 242,
  parameter logic [BYTE_W-1:0] MASK_INIT  = 8'h2A
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sof,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              mask_wr,
  input  logic [BYTE_W-1:0] mask_wr_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [BYTE_W-1:0] out_data,
  output logic [1:0]        out_class
);
  logic [BYTE_W-1:0] mask_q;
  logic [BYTE_W-1:0] xf_data;
  logic              accept;
  byte_class_e       cur_cls;
  byte_class_e       oc;

  assign accept    = in_valid && in_ready;
  assign out_class = oc;

  always_ff @(posedge clk) begin
    if (rst)          mask_q <= MASK_INIT;
    else if (mask_wr) mask_q <= mask_wr_data;
  end

  tfr_position #(
    .SYNC_BYTES(SYNC_BYTES),
    .DATA_BYTES(DATA_BYTES)
  ) pos_i (
    .clk   (clk),
    .rst   (rst),
    .sof_i (sof),
    .step_i(accept),
    .cls_o (cur_cls)
  );

  tfr_byte_xform #(.BYTE_W(BYTE_W)) xf_i (
    .byte_i(in_data),
    .mask_i(mask_q),
    .cls_i (cur_cls),
    .byte_o(xf_data)
  );

  tfr_out_stage #(.BYTE_W(BYTE_W)) os_i (
    .clk        (clk),
    .rst        (rst),
    .load_i     (accept),
    .data_i     (xf_data),
    .cls_i      (cur_cls),
    .out_ready_i(out_ready),
    .ready_o    (in_ready),
    .out_valid_o(out_valid),
    .out_data_o (out_data),
    .out_class_o(oc)
  );

  AST_CLASS_LEGAL: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> oc != CLS_NONE); // R3
  AST_SYNC_PASS: assert property (@(posedge clk) disable iff (rst)
    (accept && cur_cls != CLS_DATA) |=> (out_data == $past(in_data))); // R5
  AST_ACCEPT_SHOWS: assert property (@(posedge clk) disable iff (rst)
    accept |=> out_valid); // R9
endmodule

// File: tb/tlm_frame_reformatter_tb_top.sv
`timescale 1ns/1ps
module tlm_frame_reformatter_tb_top;
  localparam int SB = 4;
  localparam int DB = 12;
  localparam int FRAME = SB + 1 + DB;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sof = 1'b0, in_valid = 1'b0, mask_wr = 1'b0, out_ready = 1'b0;
  logic [7:0] in_data = '0, mask_wr_data = '0;
  logic       in_ready, out_valid;
  logic [7:0] out_data;
  logic [1:0] out_class;

  int  n_cmp = 0, n_bad = 0;
  bit  done = 0;
  string req_tag = "R2";

  always #10 clk = ~clk;

  tlm_frame_reformatter #(.BYTE_W(8), .SYNC_BYTES(SB), .DATA_BYTES(DB), .MASK_INIT(8'h2A)) dut_i (
    .clk(clk), .rst(rst), .sof(sof), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .mask_wr(mask_wr), .mask_wr_data(mask_wr_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_class(out_class)
  );

  // Behavioural reference model
  int         m_pos;
  logic [7:0] m_mask;
  logic       m_valid;
  logic [7:0] m_data;
  logic [1:0] m_cls;

  function automatic logic [7:0] flip(input logic [7:0] b);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = b[7-i];
    return r;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_pos <= 0; m_mask <= 8'h2A; m_valid <= 1'b0; m_data <= '0; m_cls <= 2'b00;
    end else begin
      int p;
      logic acc;
      logic [1:0] c;
      p   = sof ? 0 : m_pos;
      acc = in_valid && (!m_valid || out_ready);
      c   = (p < SB) ? 2'b01 : ((p == SB) ? 2'b10 : 2'b11);
      if (acc) begin
        m_valid <= 1'b1;
        m_cls   <= c;
        m_data  <= (c == 2'b11) ? (flip(in_data) ^ m_mask) : in_data;
        m_pos   <= (p + 1) % FRAME;
      end else begin
        if (out_ready) m_valid <= 1'b0;
        if (sof) m_pos <= 0;
      end
      if (mask_wr) m_mask <= mask_wr_data;
    end
  end

  task automatic check(input string r, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", r, what, act, exp, $time);
    end
  endtask

  // Compare late in each cycle, well after the inputs were driven.
  always @(negedge clk) begin
    #8;
    if (!rst && !done) begin
      check("R9", "in_ready", in_ready, (!m_valid || out_ready));
      check("R8", "out_valid", out_valid, m_valid);
      if (m_valid) begin
        check("R3", "out_class", out_class, m_cls);
        if (m_cls == 2'b11) check(req_tag, "data byte", out_data, m_data);
        else                check("R5", "pass byte", out_data, m_data);
      end
    end
  end

  task automatic drive(input logic v, input logic [7:0] d, input logic s,
                       input logic rd, input logic mw, input logic [7:0] md);
    @(negedge clk); #1;
    in_valid = v; in_data = d; sof = s; out_ready = rd; mask_wr = mw; mask_wr_data = md;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL R9 watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); #1; rst = 1'b0;
    @(negedge clk); #8;
    // R1: reset state at the ports
    check("R1", "out_valid after reset", out_valid, 0);
    check("R1", "in_ready after reset", in_ready, 1);

    // R1/R4: full rate frames with the reset mask, first byte aligned by reset
    req_tag = "R4";
    for (int i = 0; i < 3 * FRAME; i++) drive(1'b1, 8'(i * 37 + 5), 1'b0, 1'b1, 1'b0, 8'h00);
    // R2: several frames with patterned bytes and a strobe at the start
    req_tag = "R2";
    drive(1'b1, 8'h01, 1'b1, 1'b1, 1'b0, 8'h00);
    for (int i = 0; i < 2 * FRAME; i++) drive(1'b1, 8'(1 << (i % 8)), 1'b0, 1'b1, 1'b0, 8'h00);

    // R8: random valid/ready with back-pressure
    req_tag = "R8";
    for (int i = 0; i < 600; i++)
      drive(($urandom % 10) < 7, 8'($urandom), 1'b0, ($urandom % 10) < 5, 1'b0, 8'h00);

    // R6: mask writes, some in the same cycle as an accepted data byte
    req_tag = "R6";
    for (int i = 0; i < 500; i++)
      drive(($urandom % 10) < 8, 8'($urandom), 1'b0, ($urandom % 10) < 7,
            ($urandom % 6) == 0, 8'($urandom));

    // R7: strobes anywhere, with and without an accepted byte
    req_tag = "R7";
    for (int i = 0; i < 800; i++)
      drive(($urandom % 10) < 7, 8'($urandom), ($urandom % 15) == 0, ($urandom % 10) < 6,
            ($urandom % 20) == 0, 8'($urandom));
    // R7: strobe on an idle cycle mid-frame, then a burst
    for (int i = 0; i < 7; i++) drive(1'b1, 8'(i), 1'b0, 1'b1, 1'b0, 8'h00);
    drive(1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 8'h00);
    for (int i = 0; i < FRAME + 3; i++) drive(1'b1, 8'(8'hC3 + i), 1'b0, 1'b1, 1'b0, 8'h00);

    // R9: drain
    req_tag = "R9";
    for (int i = 0; i < 4; i++) drive(1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 8'h00);
    @(negedge clk); #9;
    finish_run();
  end
endmodule